// File: doc/BRIEF.md
# Serial Seven-Bit Pattern Detector

This block watches a single-bit serial stream and raises a flag when the seven most recent bits, in arrival order, read 0110011 (the leftmost 0 arrives first). It is a Moore machine: the flag comes from the state register alone. It therefore appears in the clock cycle after the edge that sampled the final 1 of the pattern, and it lasts exactly one cycle.

Eight states are held in three flip-flops. Each state stands for how many leading pattern bits are currently matched, from zero to all seven. The codes follow a fixed assignment in which many frequent transitions change a single bit. On a mismatch the machine does not simply restart. It moves to the state for the longest tail of the received bits that is also a head of the pattern. As a result, overlapping occurrences are all reported.

Top module: `pattern_detector`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge puts the machine in its idle (zero-matched) state, code 3'b000, and `match` reads 0 in the following cycle; a partial pattern seen before reset does not count toward a later match.
- R2: `din` is sampled on each rising edge. `match` is 1 during the cycle after the edge that sampled the last bit of 0110011 (oldest bit first) and 0 in every other cycle.
- R3: `match` depends only on the state register. It is 1 only in the all-matched state, code 3'b100. The remaining codes are: idle 000, one matched 111, two 101, three 001, four 010, five 110, six 011.
- R4: Overlapping occurrences are detected. When the pattern completes and the next bit is 0, the machine keeps 0110 as matched, so the four further bits 0011 produce a second pulse.
- R5: On a mismatch, the next state reflects the longest suffix of the received bits that is also a prefix of the pattern. For example, 01101 leaves 01 matched, so 10011 then completes a match.
- R6: `match` is never high in two consecutive cycles; successive pulses are at least four cycles apart.
- R7: In the idle state, a 1 on `din` leaves the machine idle, so any run of leading ones has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| match | output | 1 | High for one cycle after 0110011 has been received |

## Verification
The block has no tunable parameters, so the bench builds it as is: seven-bit pattern and three-bit state. That small size makes an exhaustive sweep practical. The bench applies every 12-bit stream after a reset, so every path through all eight states is reached, including each fallback and overlap edge. A long pseudo-random stream and directed sequences for reset, overlap and fallback follow. Each cycle, `match` is compared with a reference computed from a seven-bit history of the driven bits.

// File: rtl/det_pkg.sv
package det_pkg;

    // Number of bits in the searched pattern; oldest bit is the MSB.
    localparam int unsigned PAT_LEN   = 7;
    localparam logic [PAT_LEN-1:0] PATTERN = 7'b0110011;
    localparam int unsigned NUM_ST    = PAT_LEN + 1;
    localparam int unsigned ST_W      = $clog2(NUM_ST);

    // State name = number of leading pattern bits matched.
    typedef enum logic [ST_W-1:0] {
        ST_M0 = 3'b000,
        ST_M1 = 3'b111,
        ST_M2 = 3'b101,
        ST_M3 = 3'b001,
        ST_M4 = 3'b010,
        ST_M5 = 3'b110,
        ST_M6 = 3'b011,
        ST_M7 = 3'b100
    } det_state_e;

    typedef struct packed {
        det_state_e state;
    } det_regs_t;

endpackage

// File: rtl/det_next_state.sv
module det_next_state
    import det_pkg::*;
(
    input  det_state_e cur,
    input  logic       bit_in,
    output det_state_e nxt
);

    // Transition table: match advances one step; mismatch falls back to the
    // longest suffix of the received bits that is still a pattern prefix.
    always_comb begin
        nxt = ST_M0;
        unique case (cur)
            ST_M0: nxt = bit_in ? ST_M0 : ST_M1;   // "" -> "0"
            ST_M1: nxt = bit_in ? ST_M2 : ST_M1;   // "00" keeps "0"
            ST_M2: nxt = bit_in ? ST_M3 : ST_M1;   // "010" keeps "0"
            ST_M3: nxt = bit_in ? ST_M0 : ST_M4;   // "0111" keeps nothing
            ST_M4: nxt = bit_in ? ST_M2 : ST_M5;   // "01101" keeps "01"
            ST_M5: nxt = bit_in ? ST_M6 : ST_M1;   // "011000" keeps "0"
            ST_M6: nxt = bit_in ? ST_M7 : ST_M1;   // "0110010" keeps "0"
            ST_M7: nxt = bit_in ? ST_M0 : ST_M4;   // overlap keeps "0110"
            default: nxt = ST_M0;
        endcase
    end

endmodule

// File: rtl/det_hit_decode.sv
module det_hit_decode
    import det_pkg::*;
(
    input  det_state_e state,
    output logic       hit
);

    always_comb begin
        hit = (state == ST_M7);
    end

endmodule

// File: rtl/pattern_detector.sv
module pattern_detector
    import det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic match
);

    det_regs_t  regs_d;
    det_regs_t  regs_q;
    det_state_e nxt_state;

    det_next_state u_next (
        .cur    (regs_q.state),
        .bit_in (din),
        .nxt    (nxt_state)
    );

    always_comb begin
        regs_d = regs_q;
        regs_d.state = nxt_state;
        if (rst) begin
            regs_d.state = ST_M0;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    det_hit_decode u_decode (
        .state (regs_q.state),
        .hit   (match)
    );

    // R1: reset clears the output on the next cycle
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> !match);

    // R2: a pulse always follows a sampled 1 (last pattern bit)
    p_match_after_one_r2: assert property (@(posedge clk) disable iff (rst)
        match |-> $past(din));

    // R4: after a completed match a 0 keeps four bits matched
    p_overlap_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (match && !din) |=> (regs_q.state == ST_M4));

    // R5: 01101 falls back to 01 matched
    p_fallback_r5: assert property (@(posedge clk) disable iff (rst)
        ((regs_q.state == ST_M4) && din) |=> (regs_q.state == ST_M2));

    // R6: no back-to-back pulses
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        match |=> !match);

    // R7: a 1 in idle stays idle
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((regs_q.state == ST_M0) && din) |=> (regs_q.state == ST_M0));

endmodule

// File: tb/pattern_detector_bench.sv
`timescale 1ns/1ps
module pattern_detector_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic match;

    int n_checks = 0;
    int n_fail   = 0;
    logic [6:0] hist = '0;
    int seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pattern_detector u_pattern_detector (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .match (match)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: match=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply reset for one edge; R1 says match is 0 afterwards.
    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hist = '0;
        seen = 0;
        check("R1", match, 1'b0);
    endtask

    // Drive one bit, let it be sampled, compare against the history model (R2).
    task automatic step(input logic b, input string req);
        din = b;
        @(posedge clk);
        hist = {hist[5:0], b};
        seen++;
        @(negedge clk);
        check(req, match, (seen >= 7) && (hist == 7'b0110011));
    endtask

    task automatic feed(input logic [31:0] bits, input int len, input string req);
        for (int i = len - 1; i >= 0; i--) step(bits[i], req);
    endtask

    initial begin
        logic [15:0] lfsr;
        int last_hit;
        @(negedge clk);
        do_reset();

        // R2 basic detection
        feed(32'b0110011, 7, "R2");
        check("R2", match, 1'b1);
        step(1'b1, "R2");
        check("R2", match, 1'b0);

        // R7 leading ones then pattern
        do_reset();
        feed(32'b1111, 4, "R7");
        check("R7", match, 1'b0);
        feed(32'b0110011, 7, "R7");
        check("R7", match, 1'b1);

        // R4 overlap: 0110011 then 0011
        do_reset();
        feed(32'b0110011, 7, "R4");
        feed(32'b0011, 4, "R4");
        check("R4", match, 1'b1);

        // R5 fallback: 01101 then 10011
        do_reset();
        feed(32'b01101, 5, "R5");
        feed(32'b10011, 5, "R5");
        check("R5", match, 1'b1);

        // R1 reset mid-pattern discards progress
        do_reset();
        feed(32'b011001, 6, "R1");
        do_reset();
        step(1'b1, "R1");
        check("R1", match, 1'b0);

        // R3 exhaustive: all 12-bit streams after reset
        for (int v = 0; v < 4096; v++) begin
            do_reset();
            feed(32'(v), 12, "R3");
        end

        // R6 long pseudo-random stream, pulse spacing >= 4
        do_reset();
        lfsr = 16'hACE1;
        last_hit = -100;
        for (int c = 0; c < 20000; c++) begin
            step(lfsr[0], "R6");
            if (match) begin
                check("R6", (c - last_hit) >= 4, 1'b1);
                last_hit = c;
            end
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule